// File: doc/BRIEF.md
# ADC conversion control unit

This block is the digital control and sequencing logic placed in front of a successive-approximation converter. Software sees a single 8-bit register on a simple write-strobe bus. The register holds the settings: power-up, kick-off, automatic triggering, interrupt enable and a clock divider choice. It also shows two pieces of status: a busy indication and a done flag. From the system clock the block derives a slower conversion clock tick. It counts conversion cycles on that tick. When a conversion ends it latches the 10-bit value offered by the converter model, sets the done flag and, when permitted, requests an interrupt.

A conversion can begin in three ways. Software can request one. A rising edge on the trigger input can start one when automatic triggering is on. With automatic triggering on and the free-run select input high, conversions follow one another without a gap. The first conversion after power-up is a longer initialising one. Clearing the power-up bit abandons any conversion at once.

Top module: `adc_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the interrupt request is low and the result is 0.
- R2: Register fields are: bit 7 power-up, bit 6 start/busy, bit 5 auto-trigger, bit 4 done flag, bit 3 interrupt enable, bits 2:0 divider select. Power-up, auto-trigger, interrupt enable and divider select read back exactly as last written.
- R3: The conversion tick occurs once every 2 system clocks for divider codes 0 and 1, and once every 2^code system clocks for codes 2 to 7. The divider restarts its count when power-up is set.
- R4: The first conversion after power-up lasts 25 ticks, also when start and power-up are written together. Every later conversion lasts 13 ticks. A conversion kicked off together with power-up keeps bit 6 high for exactly 25 times the divide ratio in system clocks.
- R5: Writing 1 to bit 6 while powered and idle starts a conversion, and bit 6 reads 1 from the next cycle until completion. Writing 0 to bit 6 has no effect, and writing 1 while busy does not restart.
- R6: A write that clears power-up during a conversion drops bit 6 in the next cycle. It leaves the flag and the result unchanged, and makes the next conversion an initialising one.
- R7: With auto-trigger set, power-up set and free-run select low, a rising edge of the trigger input starts a conversion. The edge is sampled on the system clock. Edges seen while busy, or while auto-trigger is clear, are dropped without being queued.
- R8: With auto-trigger set and free-run select high, after a software start each completion starts the next 13-tick conversion at once, until power-up is cleared.
- R9: At completion the result takes the converter value and the flag sets in the same cycle. The flag clears when a write has bit 4 set or when the acknowledge input is high. Setting wins over clearing, and a write with bit 4 clear leaves the flag alone.
- R10: The interrupt request is high exactly when the flag, the interrupt enable bit and the global enable input are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| trig_i | input | 1 | External trigger source |
| free_run_i | input | 1 | Selects free-running operation when auto-trigger is set |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| conv_data_i | input | 10 | Value from the converter model |
| result_o | output | 10 | Latched conversion result |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are those where a register write meets the divider phase or a completion. Examples are an abort a few ticks into a first conversion, a trigger edge arriving mid-conversion, and a flag clear in the same cycle as a set. The stimulus drives writes, trigger pulses and acknowledges at chosen cycle offsets. A behavioural model built from counters tracks the divider phase and the tick count and is compared with every output on each clock. Directed measurements of busy length and of the spacing between results pin down the 25- and 13-tick lengths at several divider codes.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int REG_W     = 8;
  localparam int PS_W      = 3;
  localparam int BIT_EN    = 7;
  localparam int BIT_START = 6;
  localparam int BIT_AUTO  = 5;
  localparam int BIT_FLAG  = 4;
  localparam int BIT_IE    = 3;
  localparam int INIT_LEN  = 25;
  localparam int NORM_LEN  = 13;

  typedef struct packed {
    logic            en;
    logic            auto_trig;
    logic            ie;
    logic [PS_W-1:0] ps;
  } cfg_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  int shift;

  always_comb begin
    shift = (int'(sel_i) < 2) ? 1 : int'(sel_i);
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < shift);
    tick_o = en_i && ((cnt_q & mask) == mask);
    cnt_d  = en_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int FIRST_LEN = 25,
  parameter int LATER_LEN = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic start_i,
  input  logic tick_i,
  input  logic cont_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CYC_W = $clog2(FIRST_LEN);

  logic             busy_q, busy_d, first_q, first_d;
  logic [CYC_W-1:0] cyc_q, cyc_d, last_cyc;

  always_comb begin
    last_cyc = first_q ? CYC_W'(FIRST_LEN - 1) : CYC_W'(LATER_LEN - 1);
    done_o   = busy_q && tick_i && (cyc_q == last_cyc);
    busy_d   = busy_q;
    cyc_d    = cyc_q;
    first_d  = first_q;
    if (!en_i) begin
      busy_d  = 1'b0;
      cyc_d   = '0;
      first_d = 1'b1;
    end else if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cyc_d  = '0;
    end else if (busy_q && tick_i) begin
      if (done_o) begin
        first_d = 1'b0;
        cyc_d   = '0;
        busy_d  = cont_i;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b1;
      cyc_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      first_q <= first_d;
      cyc_q   <= cyc_d;
    end
  end

  assign busy_o = busy_q;

  // R4
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cyc_q) < FIRST_LEN));
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done_o || !en_i));
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             trig_i,
  input  logic             free_run_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);
  cfg_t             cfg_q, cfg_d;
  logic             flag_q, flag_d, trig_q, trig_edge;
  logic             start_req, cont, tick, busy, seq_done;
  logic [RES_W-1:0] result_q, result_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) begin
      cfg_d.en        = wr_data_i[BIT_EN];
      cfg_d.auto_trig = wr_data_i[BIT_AUTO];
      cfg_d.ie        = wr_data_i[BIT_IE];
      cfg_d.ps        = wr_data_i[PS_W-1:0];
    end
    trig_edge = trig_i && !trig_q;
    start_req = cfg_d.en && ((wr_en_i && wr_data_i[BIT_START]) ||
                (cfg_q.auto_trig && cfg_q.en && !free_run_i && trig_edge));
    cont      = cfg_q.auto_trig && free_run_i;
    if (seq_done)                                        flag_d = 1'b1;
    else if ((wr_en_i && wr_data_i[BIT_FLAG]) || irq_ack_i) flag_d = 1'b0;
    else                                                 flag_d = flag_q;
    result_d = seq_done ? conv_data_i : result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      flag_q   <= 1'b0;
      trig_q   <= 1'b0;
      result_q <= '0;
    end else begin
      cfg_q    <= cfg_d;
      flag_q   <= flag_d;
      trig_q   <= trig_i;
      result_q <= result_d;
    end
  end

  adc_clk_div #(.SEL_W(PS_W), .CNT_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .en_i(cfg_q.en), .sel_i(cfg_q.ps), .tick_o(tick)
  );

  adc_conv_seq #(.FIRST_LEN(INIT_LEN), .LATER_LEN(NORM_LEN)) i_seq (
    .clk(clk), .rst_n(rst_n), .en_i(cfg_d.en), .start_i(start_req),
    .tick_i(tick), .cont_i(cont), .busy_o(busy), .done_o(seq_done)
  );

  assign rd_data_o = {cfg_q.en, busy, cfg_q.auto_trig, flag_q, cfg_q.ie, cfg_q.ps};
  assign result_o  = result_q;
  assign irq_o     = flag_q && cfg_q.ie && gie_i;

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(seq_done));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> $stable(result_q));
  // R6
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |-> !busy);
endmodule

// File: tb/test_adc_ctrl.sv
module test_adc_ctrl;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       trig = 1'b0, free_run = 1'b0, gie = 1'b0, irq_ack = 1'b0;
  logic [9:0] conv_data, result;
  logic       irq;
  int         tc = 0;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) tc <= tc + 1;
  assign conv_data = 10'(tc * 7 + 3);

  adc_ctrl i_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .trig_i(trig), .free_run_i(free_run), .gie_i(gie),
    .irq_ack_i(irq_ack), .conv_data_i(conv_data), .result_o(result), .irq_o(irq)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, tc, act, exp);
    end
  endtask

  // Reference model: counters and flags derived from the requirements
  bit m_en = 0, m_auto = 0, m_ie = 0, m_flag = 0, m_busy = 0, m_first = 1, m_trig = 0;
  int m_ps = 0, m_cyc = 0, m_pcnt = 0, m_res = 0;

  always @(posedge clk) begin
    int  div, len;
    bit  tick, done, edge_s, en_n, st;
    if (!rst_n) begin
      m_en = 0; m_auto = 0; m_ie = 0; m_flag = 0; m_busy = 0; m_first = 1;
      m_trig = 0; m_ps = 0; m_cyc = 0; m_pcnt = 0; m_res = 0;
    end else begin
      div    = (m_ps < 2) ? 2 : (1 << m_ps);
      tick   = m_en && ((m_pcnt % div) == div - 1);
      len    = m_first ? 25 : 13;
      done   = m_busy && tick && (m_cyc == len - 1);
      edge_s = trig && !m_trig;
      en_n   = wr_en ? wr_data[7] : m_en;
      st     = en_n && !m_busy &&
               ((wr_en && wr_data[6]) || (m_auto && m_en && !free_run && edge_s));
      if (done) m_res = int'(conv_data);
      if (done) m_flag = 1;
      else if ((wr_en && wr_data[4]) || irq_ack) m_flag = 0;
      if (!en_n) begin
        m_busy = 0; m_cyc = 0; m_first = 1;
      end else if (st) begin
        m_busy = 1; m_cyc = 0;
      end else if (m_busy && tick) begin
        if (done) begin
          m_first = 0; m_cyc = 0; m_busy = m_auto && free_run;
        end else m_cyc++;
      end
      m_pcnt = m_en ? (m_pcnt + 1) % 128 : 0;
      if (wr_en) begin
        m_en = wr_data[7]; m_auto = wr_data[5]; m_ie = wr_data[3]; m_ps = int'(wr_data[2:0]);
      end
      m_trig = trig;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 en",    int'(rd_data[7]), int'(m_en));
      chk("R5 busy",  int'(rd_data[6]), int'(m_busy));
      chk("R2 auto",  int'(rd_data[5]), int'(m_auto));
      chk("R9 flag",  int'(rd_data[4]), int'(m_flag));
      chk("R2 ie",    int'(rd_data[3]), int'(m_ie));
      chk("R2 ps",    int'(rd_data[2:0]), m_ps);
      chk("R9 result", int'(result), m_res);
      chk("R10 irq",  int'(irq), int'(m_flag && m_ie && gie));
    end
  end

  always @(posedge clk) begin
    if (tc > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog at cycle %0d: actual hung expected done", tc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    do begin
      @(negedge clk);
      if (rd_data[6]) n++;
    end while (rd_data[6]);
    step(1);
  endtask

  task automatic next_result(output int at);
    logic [9:0] r;
    r = result;
    while (result == r) @(negedge clk);
    at = tc;
  endtask

  initial begin
    int n, t1, t2, t3;
    logic [9:0] r0, r1;
    logic f0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    chk("R1 reg", int'(rd_data), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 result", int'(result), 0);

    // R2
    wr(8'h2B);
    chk("R2 readback", int'(rd_data), 'h2B);
    wr(8'h00);

    // R3 R4: initialising conversion length per divider code
    foreach (n_codes[k]) begin
      int code, div;
      code = n_codes[k];
      div  = (code < 2) ? 2 : (1 << code);
      wr(8'hC0 | 8'(code));
      busy_len(n);
      chk("R3 R4 init length", n, 25 * div);
      wr(8'h10);
    end

    // R4 later conversion
    wr(8'hC0);
    busy_len(n);
    chk("R4 first", n, 50);
    wr(8'hC0);
    busy_len(n);
    chk("R4 later", int'(n >= 25 && n <= 26), 1);

    // R5
    wr(8'h80);
    step(3);
    chk("R5 write zero idle", int'(rd_data[6]), 0);
    wr(8'hC0);
    step(2);
    wr(8'h80);
    chk("R5 write zero busy", int'(rd_data[6]), 1);
    wr(8'hC0);
    busy_len(n);
    chk("R5 no restart", int'(n < 26), 1);

    // R6 abort
    wr(8'h00);
    wr(8'hC0);
    step(10);
    r0 = result; f0 = rd_data[4];
    wr(8'h00);
    chk("R6 busy drop", int'(rd_data[6]), 0);
    step(60);
    chk("R6 result kept", int'(result), int'(r0));
    chk("R6 flag kept", int'(rd_data[4]), int'(f0));
    wr(8'hC0);
    busy_len(n);
    chk("R6 reinit length", n, 50);

    // R10 R9
    wr(8'h88);
    chk("R10 gie low", int'(irq), 0);
    gie = 1'b1; #1;
    chk("R10 all set", int'(irq), 1);
    wr(8'h80);
    chk("R10 ie low", int'(irq), 0);
    wr(8'h88);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    chk("R9 ack clear", int'(rd_data[4]), 0);
    wr(8'hC8);
    busy_len(n);
    chk("R9 flag set", int'(rd_data[4]), 1);
    wr(8'h98);
    chk("R9 w1c", int'(rd_data[4]), 0);

    // R7
    wr(8'hA0);
    r0 = result;
    trig = 1'b1; step(1);
    chk("R7 edge starts", int'(rd_data[6]), 1);
    trig = 1'b0; step(5);
    trig = 1'b1; step(1); trig = 1'b0;
    busy_len(n);
    r1 = result;
    chk("R7 completed", int'(r1 != r0), 1);
    step(40);
    chk("R7 not queued", int'(result), int'(r1));
    chk("R7 idle", int'(rd_data[6]), 0);
    wr(8'h80);
    trig = 1'b1; step(1); trig = 1'b0; step(1);
    chk("R7 auto off", int'(rd_data[6]), 0);

    // R8
    wr(8'h00);
    free_run = 1'b1;
    wr(8'hE0);
    next_result(t1);
    next_result(t2);
    next_result(t3);
    chk("R8 spacing a", t2 - t1, 26);
    chk("R8 spacing b", t3 - t2, 26);
    step(1);
    wr(8'h00);
    r0 = result;
    step(100);
    chk("R8 stopped", int'(rd_data[6]), 0);
    chk("R8 result still", int'(result), int'(r0));
    free_run = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int n_codes[6] = '{0, 1, 2, 3, 4, 6};
endmodule